// File: doc/BRIEF.md
# PCI Configuration Register File with Per-Byte Write Masks

This block holds the 256-byte configuration space of a type-0 PCI function. Every byte carries a write mask fixed at elaboration, so a configuration write can only change the bits that its mask allows. The other bits keep their value, or keep the constant that the byte holds. Identity fields (vendor, device, revision, class code) come from parameters and cannot be written. The size of each base address register is set by a parameter. From that size the block derives the mask that lets software discover the region size by writing all ones and reading the result back.

Requests are byte-addressed and carry 1, 2 or 4 bytes in little-endian order. A write takes effect at the clock edge that accepts it. A read returns its data one cycle later, right-aligned. The block drives the command register, the raw BAR words and the expansion ROM word to a downstream address decoder. It also raises a one-cycle pulse whenever a write changes what that decoder must map.

Top module: `pci_cfg_space`

## Requirements
- R1: After reset the identity bytes read their parameter values: offsets 0x00–0x01 hold the vendor ID, 0x02–0x03 the device ID, 0x08 the revision and 0x09–0x0B the class code. The command register, cache line size, interrupt line and bytes 0x40–0xFF read 0. Each implemented BAR reads only its type bits: bit 0 is 1 for an I/O region and 0 for a memory region.
- R2: A read request (req_write = 0) makes rd_valid high in the next cycle and only then. rd_data bits [8k+7:8k] hold the byte at req_addr + k. req_size 2'b00 selects 1 byte, 2'b01 selects 2 bytes, and 2'b10 or 2'b11 select 4 bytes. Lanes beyond the size, and lanes whose address passes 0xFF, read 0.
- R3: A write updates each addressed byte to (old AND NOT mask) OR (new AND mask) at the edge that accepts it. A read issued in the very next cycle returns the merged value.
- R4: The vendor ID, device ID, revision, class code, header type (0x0E, value 0x00), capability pointer (0x34), status (0x06–0x07) and every other byte not named in R5 to R8 ignore writes.
- R5: In the command register (0x04–0x05) only bit 0 (I/O enable), bit 1 (memory enable) and bit 2 (bus master enable) are writable. Cache line size (0x0C), interrupt line (0x3C) and every byte from 0x40 to 0xFF are fully writable.
- R6: BAR n sits at offset 0x10 + 4n. Its write mask is NOT (size − 1), so after an all-ones write it reads (NOT (size − 1)) OR type. Its bits below log2(size) always read the type encoding.
- R7: The expansion ROM BAR at 0x30 has the write mask (NOT (size − 1)) OR 1. Bit 0 is the enable and stays writable, and bits 1 to log2(size) − 1 read 0.
- R8: A BAR whose size parameter is 0 is absent. All four of its bytes read 0xFF and ignore writes.
- R9: A multi-byte write that runs past offset 0xFF updates only its in-range bytes. The other bytes are dropped and do not wrap, and no error is raised.
- R10: map_changed is high for exactly the cycle after a write that changes any byte in 0x10–0x27, or that toggles command bit 0 or bit 1. A write that changes only the bus master bit, only the ROM BAR or nothing at all does not raise it.
- R11: cmd_word shows bytes 0x04–0x05. bar_raw bits [32n+31:32n] show BAR n. rom_raw shows bytes 0x30–0x33. All three reflect a write from the cycle after the write is accepted.
- R12: A synchronous active-low reset returns every writable byte to its initial value. This clears the three command enables, cache line size and interrupt line, and rewrites each implemented BAR with only its type bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset of the first byte |
| req_size | input | 2 | 00: 1 byte, 01: 2 bytes, 1x: 4 bytes |
| req_wdata | input | 32 | Write data, first byte in bits [7:0] |
| rd_valid | output | 1 | Read data valid (one cycle after a read request) |
| rd_data | output | 32 | Read data, right-aligned, unused lanes 0 |
| cmd_word | output | 16 | Command register |
| bar_raw | output | 192 | Six raw BAR words, BAR n at [32n+31:32n] |
| rom_raw | output | 32 | Raw expansion ROM BAR word |
| map_changed | output | 1 | One-cycle pulse after a mapping-relevant change |

## Verification
Two functions can fall in the same cycle: the commit of a write, together with its map_changed pulse, and a read request for the very bytes that write just merged. The bench issues a write and a read of the same offset back to back. It judges the pulse in the cycle of the read request and judges the returned data against a bench-side byte model one cycle later. The same model, which keeps its own copy of the masks, also predicts the pulse for every random write. That includes writes that leave BAR bytes unchanged, writes that flip only the bus master bit, and writes that straddle offset 0xFF.

// File: rtl/pcicfg_pkg.sv
// pcicfg_pkg: shared constants and elaboration-time functions for the
// configuration register file. Assumes a 256-byte type-0 layout with six
// BARs and one expansion ROM BAR; region sizes are given as log2 values,
// 0 meaning the region is absent.
package pcicfg_pkg;

    localparam int unsigned CFG_BYTES = 256;
    localparam int unsigned CFG_AW    = 8;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned LANES     = DATA_W / 8;
    localparam int unsigned NUM_BARS  = 6;
    localparam int unsigned IMG_W     = CFG_BYTES * 8;

    localparam int unsigned OFS_CMD   = 'h04;
    localparam int unsigned OFS_CLS   = 'h0C;
    localparam int unsigned OFS_BAR0  = 'h10;
    localparam int unsigned OFS_BAREND = OFS_BAR0 + 4 * NUM_BARS;
    localparam int unsigned OFS_ROM   = 'h30;
    localparam int unsigned OFS_INTL  = 'h3C;
    localparam int unsigned OFS_DEV   = 'h40;

    localparam logic [7:0] CMD_WMASK  = 8'h07;

    // Number of bytes carried by a request size code.
    function automatic logic [2:0] size_to_count(input logic [1:0] sz);
        case (sz)
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Write mask of one region word; the ROM keeps its enable bit writable.
    function automatic logic [31:0] region_wmask(input logic [7:0] lg, input logic is_rom);
        if (lg == 8'd0) return 32'd0;
        return ~((32'd1 << lg) - 32'd1) | {31'd0, is_rom};
    endfunction

    // Reset value of one region word: type bits, or all ones when absent.
    function automatic logic [31:0] region_init(input logic [7:0] lg, input logic is_io);
        if (lg == 8'd0) return 32'hFFFF_FFFF;
        return {31'd0, is_io};
    endfunction

    // Write mask of configuration byte a.
    function automatic logic [7:0] byte_wmask(input int unsigned a,
                                              input logic [47:0] bar_lg,
                                              input logic [7:0]  rom_lg);
        logic [31:0] m;
        int unsigned n, k;
        if (a == OFS_CMD) return CMD_WMASK;
        if (a == OFS_CLS || a == OFS_INTL || a >= OFS_DEV) return 8'hFF;
        if (a >= OFS_BAR0 && a < OFS_BAREND) begin
            n = (a - OFS_BAR0) / 4;
            k = (a - OFS_BAR0) % 4;
            m = region_wmask(bar_lg[n*8 +: 8], 1'b0);
            return m[k*8 +: 8];
        end
        if (a >= OFS_ROM && a < OFS_ROM + 4) begin
            m = region_wmask(rom_lg, 1'b1);
            return m[(a - OFS_ROM)*8 +: 8];
        end
        return 8'h00;
    endfunction

    // Initial (and reset) value of configuration byte a.
    function automatic logic [7:0] byte_init(input int unsigned a,
                                             input logic [15:0] vendor,
                                             input logic [15:0] device,
                                             input logic [7:0]  rev,
                                             input logic [23:0] cls_code,
                                             input logic [47:0] bar_lg,
                                             input logic [5:0]  bar_io,
                                             input logic [7:0]  rom_lg);
        logic [31:0] v;
        int unsigned n, k;
        case (a)
            0:  return vendor[7:0];
            1:  return vendor[15:8];
            2:  return device[7:0];
            3:  return device[15:8];
            8:  return rev;
            9:  return cls_code[7:0];
            10: return cls_code[15:8];
            11: return cls_code[23:16];
            default: ;
        endcase
        if (a >= OFS_BAR0 && a < OFS_BAREND) begin
            n = (a - OFS_BAR0) / 4;
            k = (a - OFS_BAR0) % 4;
            v = region_init(bar_lg[n*8 +: 8], bar_io[n]);
            return v[k*8 +: 8];
        end
        if (a >= OFS_ROM && a < OFS_ROM + 4) begin
            v = region_init(rom_lg, 1'b0);
            return v[(a - OFS_ROM)*8 +: 8];
        end
        return 8'h00;
    endfunction

endpackage

// File: rtl/pcicfg_lane_decode.sv
// pcicfg_lane_decode: turns one write request into a per-byte write enable
// over the whole space. Assumes the request is valid for one cycle; bytes
// past the last offset get no enable, so nothing wraps to offset 0.
module pcicfg_lane_decode
    import pcicfg_pkg::*;
(
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [CFG_AW-1:0]    req_addr,
    input  logic [1:0]           req_size,
    output logic [CFG_BYTES-1:0] byte_we
);

    logic [2:0] req_cnt;

    // Byte count of the current request.
    assign req_cnt = size_to_count(req_size);

    for (genvar a = 0; a < CFG_BYTES; a++) begin : g_we
        localparam logic [CFG_AW:0] A = (CFG_AW+1)'(a);
        logic [CFG_AW:0] off;
        // Distance of this byte above the start; wraps large when below it.
        assign off        = A - {1'b0, req_addr};
        assign byte_we[a] = req_valid & req_write & (off < {{(CFG_AW-2){1'b0}}, req_cnt});
    end

endmodule

// File: rtl/pcicfg_store.sv
// pcicfg_store: the byte array. Bytes whose mask is all zero become
// constants (no flop); the others are flops that merge write data through
// their mask. Exposes the current image and the next value of the bytes
// the mapping watcher needs. Reset is synchronous, active low.
module pcicfg_store
    import pcicfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID   = 16'h5A11,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h028000,
    parameter logic [47:0] BAR_LOG2    = {8'd0, 8'd0, 8'd0, 8'd0, 8'd8, 8'd12},
    parameter logic [5:0]  BAR_IO      = 6'b000010,
    parameter logic [7:0]  ROM_LOG2    = 8'd11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CFG_BYTES-1:0]    byte_we,
    input  logic [CFG_AW-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic [IMG_W-1:0]        cur_img,
    output logic [NUM_BARS*32-1:0]  nxt_bar,
    output logic [1:0]              nxt_cmd
);

    for (genvar a = 0; a < CFG_BYTES; a++) begin : g_byte
        localparam logic [7:0] M = byte_wmask(a, BAR_LOG2, ROM_LOG2);
        localparam logic [7:0] I = byte_init(a, VENDOR_ID, DEVICE_ID, REVISION_ID,
                                             CLASS_CODE, BAR_LOG2, BAR_IO, ROM_LOG2);
        localparam bit IN_BAR = (a >= OFS_BAR0) && (a < OFS_BAREND);

        if (M == 8'h00) begin : g_fixed
            logic unused_we;
            // Constant byte: write enable has no target.
            assign unused_we = byte_we[a];
            assign cur_img[a*8 +: 8] = I;
            if (IN_BAR) begin : g_bar_nxt
                assign nxt_bar[(a-OFS_BAR0)*8 +: 8] = I;
            end
        end else begin : g_flop
            logic [1:0] lane;
            logic [7:0] lane_d;
            logic [7:0] q;
            logic [7:0] d;
            // Request lane that carries this byte.
            assign lane   = 2'(8'(a) - req_addr);
            assign lane_d = req_wdata[{lane, 3'b000} +: 8];
            // Masked merge of write data into the held value.
            assign d      = byte_we[a] ? ((q & ~M) | (lane_d & M)) : q;
            // Hold the byte; reset restores its initial value.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= I;
                else        q <= d;
            end
            assign cur_img[a*8 +: 8] = q;
            if (IN_BAR) begin : g_bar_nxt
                assign nxt_bar[(a-OFS_BAR0)*8 +: 8] = d;
            end
            if (a == OFS_CMD) begin : g_cmd_nxt
                assign nxt_cmd = d[1:0];
            end
        end
    end

endmodule

// File: rtl/pcicfg_read_gather.sv
// pcicfg_read_gather: collects up to four bytes from the current image for
// a read request and registers them right-aligned. Lanes beyond the size or
// past the last offset return zero. Data appears one cycle after the request.
module pcicfg_read_gather
    import pcicfg_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [CFG_AW-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic [IMG_W-1:0]    cur_img,
    output logic                rd_valid,
    output logic [DATA_W-1:0]   rd_data
);

    logic [2:0]        req_cnt;
    logic [DATA_W-1:0] gathered;

    assign req_cnt = size_to_count(req_size);

    // Pick each lane's byte, or zero when out of size or out of range.
    always_comb begin
        gathered = '0;
        for (int k = 0; k < LANES; k++) begin
            logic [CFG_AW:0] pa;
            pa = {1'b0, req_addr} + (CFG_AW+1)'(k);
            if (3'(k) < req_cnt && !pa[CFG_AW])
                gathered[k*8 +: 8] = cur_img[{pa[CFG_AW-1:0], 3'b000} +: 8];
        end
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= req_valid & ~req_write;
            if (req_valid && !req_write) rd_data <= gathered;
        end
    end

endmodule

// File: rtl/pcicfg_map_watch.sv
// pcicfg_map_watch: compares the BAR bytes and the two decode enables
// against their next values and registers a one-cycle pulse when any
// differ. Assumes next values equal current ones when no write is accepted.
module pcicfg_map_watch
    import pcicfg_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_BARS*32-1:0]  cur_bar,
    input  logic [NUM_BARS*32-1:0]  nxt_bar,
    input  logic [1:0]              cur_cmd,
    input  logic [1:0]              nxt_cmd,
    output logic                    map_changed
);

    // Pulse in the cycle the new mapping becomes visible.
    always_ff @(posedge clk) begin
        if (!rst_n) map_changed <= 1'b0;
        else        map_changed <= (cur_bar != nxt_bar) || (cur_cmd != nxt_cmd);
    end

endmodule

// File: rtl/pci_cfg_space.sv
// pci_cfg_space: 256-byte type-0 configuration register file with per-byte
// write masks derived from parameters. One request per cycle; writes commit
// at the accepting edge, reads answer one cycle later. Drives the command
// word, raw BAR words and ROM word to a decoder, plus a change pulse.
module pci_cfg_space
    import pcicfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID   = 16'hC0DE,
    parameter logic [15:0] DEVICE_ID   = 16'h5A11,
    parameter logic [7:0]  REVISION_ID = 8'h03,
    parameter logic [23:0] CLASS_CODE  = 24'h028000,
    parameter logic [47:0] BAR_LOG2    = {8'd0, 8'd0, 8'd0, 8'd0, 8'd8, 8'd12},
    parameter logic [5:0]  BAR_IO      = 6'b000010,
    parameter logic [7:0]  ROM_LOG2    = 8'd11
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic           req_write,
    input  logic [7:0]     req_addr,
    input  logic [1:0]     req_size,
    input  logic [31:0]    req_wdata,
    output logic           rd_valid,
    output logic [31:0]    rd_data,
    output logic [15:0]    cmd_word,
    output logic [191:0]   bar_raw,
    output logic [31:0]    rom_raw,
    output logic           map_changed
);

    localparam int unsigned BAR_W = NUM_BARS * 32;

    logic [CFG_BYTES-1:0] byte_we;
    logic [IMG_W-1:0]     cur_img;
    logic [BAR_W-1:0]     nxt_bar;
    logic [1:0]           nxt_cmd;

    pcicfg_lane_decode u_dec (
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .byte_we   (byte_we)
    );

    pcicfg_store #(
        .VENDOR_ID   (VENDOR_ID),
        .DEVICE_ID   (DEVICE_ID),
        .REVISION_ID (REVISION_ID),
        .CLASS_CODE  (CLASS_CODE),
        .BAR_LOG2    (BAR_LOG2),
        .BAR_IO      (BAR_IO),
        .ROM_LOG2    (ROM_LOG2)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_we   (byte_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .cur_img   (cur_img),
        .nxt_bar   (nxt_bar),
        .nxt_cmd   (nxt_cmd)
    );

    pcicfg_read_gather u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .cur_img   (cur_img),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    pcicfg_map_watch u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cur_bar     (cur_img[OFS_BAR0*8 +: BAR_W]),
        .nxt_bar     (nxt_bar),
        .cur_cmd     (cur_img[OFS_CMD*8 +: 2]),
        .nxt_cmd     (nxt_cmd),
        .map_changed (map_changed)
    );

    // Decoder-facing views of the image.
    assign cmd_word = cur_img[OFS_CMD*8  +: 16];
    assign bar_raw  = cur_img[OFS_BAR0*8 +: BAR_W];
    assign rom_raw  = cur_img[OFS_ROM*8  +: 32];

endmodule

// File: rtl/pcicfg_checker.sv
// pcicfg_checker: temporal properties on the ports of pci_cfg_space,
// attached with bind. Assumes reset is held for at least two clock edges.
module pcicfg_checker #(
    parameter logic [47:0] BAR_LOG2 = {8'd0, 8'd0, 8'd0, 8'd0, 8'd8, 8'd12},
    parameter logic [5:0]  BAR_IO   = 6'b000010,
    parameter logic [7:0]  ROM_LOG2 = 8'd11
) (
    input logic         clk,
    input logic         rst_n,
    input logic         req_valid,
    input logic         req_write,
    input logic         rd_valid,
    input logic [15:0]  cmd_word,
    input logic [191:0] bar_raw,
    input logic [31:0]  rom_raw,
    input logic         map_changed
);

    p_rd_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    p_rd_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> !rd_valid);

    p_cmd_fixed_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cmd_word[15:3]));

    p_pulse_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        map_changed |-> $past(req_valid && req_write));

    p_bar_move_pulses_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bar_raw) |-> map_changed);

    p_idle_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> ($stable(bar_raw) && $stable(cmd_word) && $stable(rom_raw)));

    for (genvar n = 0; n < 6; n++) begin : g_bar
        localparam logic [7:0] LG = BAR_LOG2[n*8 +: 8];
        if (LG != 8'd0) begin : g_present
            localparam logic [31:0] LOWM = (32'd1 << LG) - 32'd1;
            localparam logic [31:0] TYP  = {31'd0, BAR_IO[n]};
            p_bar_type_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (bar_raw[n*32 +: 32] & LOWM) == TYP);
        end else begin : g_absent
            p_bar_absent_r8: assert property (@(posedge clk) disable iff (!rst_n)
                bar_raw[n*32 +: 32] == 32'hFFFF_FFFF);
        end
    end

    if (ROM_LOG2 != 8'd0) begin : g_rom
        localparam logic [31:0] ROM_LOW = ((32'd1 << ROM_LOG2) - 32'd1) & ~32'd1;
        p_rom_low_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rom_raw & ROM_LOW) == 32'd0);
    end

endmodule

bind pci_cfg_space pcicfg_checker #(
    .BAR_LOG2 (BAR_LOG2),
    .BAR_IO   (BAR_IO),
    .ROM_LOG2 (ROM_LOG2)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .rd_valid    (rd_valid),
    .cmd_word    (cmd_word),
    .bar_raw     (bar_raw),
    .rom_raw     (rom_raw),
    .map_changed (map_changed)
);

// File: tb/sim_pci_cfg_space.sv
// sim_pci_cfg_space: directed corner cases plus seeded random traffic,
// checked against a byte model built from the requirements.
module sim_pci_cfg_space;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic         req_write;
    logic [7:0]   req_addr;
    logic [1:0]   req_size;
    logic [31:0]  req_wdata;
    logic         rd_valid;
    logic [31:0]  rd_data;
    logic [15:0]  cmd_word;
    logic [191:0] bar_raw;
    logic [31:0]  rom_raw;
    logic         map_changed;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 0;
    logic [7:0] mdl [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cfg_space u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .cmd_word(cmd_word),
        .bar_raw(bar_raw), .rom_raw(rom_raw), .map_changed(map_changed)
    );

    // Masks for the default parameters (BAR0 4 KiB memory, BAR1 256 B I/O, ROM 2 KiB).
    function automatic logic [7:0] exp_mask(int a);
        if (a == 4) return 8'h07;
        if (a == 12 || a == 60 || a >= 64) return 8'hFF;
        case (a)
            'h11: return 8'hF0;
            'h12, 'h13: return 8'hFF;
            'h15, 'h16, 'h17: return 8'hFF;
            'h30: return 8'h01;
            'h31: return 8'hF8;
            'h32, 'h33: return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] exp_init(int a);
        case (a)
            0: return 8'hDE;  1: return 8'hC0;
            2: return 8'h11;  3: return 8'h5A;
            8: return 8'h03;  9: return 8'h00;
            10: return 8'h80; 11: return 8'h02;
            'h14: return 8'h01;
            default: return (a >= 'h18 && a < 'h28) ? 8'hFF : 8'h00;
        endcase
    endfunction

    function automatic int cnt_of(logic [1:0] s);
        return (s == 2'b00) ? 1 : (s == 2'b01) ? 2 : 4;
    endfunction

    task automatic model_reset();
        for (int a = 0; a < 256; a++) mdl[a] = exp_init(a);
    endtask

    task automatic model_write(input logic [7:0] ad, input logic [1:0] sz,
                               input logic [31:0] d, output bit pulse);
        logic [7:0] old_cmd;
        bit bar_moved;
        old_cmd   = mdl[4];
        bar_moved = 0;
        for (int k = 0; k < cnt_of(sz); k++) begin
            int a;
            logic [7:0] nv;
            a = int'(ad) + k;
            if (a <= 255) begin
                nv = (mdl[a] & ~exp_mask(a)) | (d[k*8 +: 8] & exp_mask(a));
                if (a >= 'h10 && a < 'h28 && nv != mdl[a]) bar_moved = 1;
                mdl[a] = nv;
            end
        end
        pulse = bar_moved || (old_cmd[1:0] != mdl[4][1:0]);
    endtask

    function automatic logic [31:0] model_read(logic [7:0] ad, logic [1:0] sz);
        logic [31:0] v;
        v = '0;
        for (int k = 0; k < cnt_of(sz); k++)
            if (int'(ad) + k <= 255) v[k*8 +: 8] = mdl[int'(ad) + k];
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outputs(input string req);
        check(cmd_word == {mdl[5], mdl[4]}, req, 32'(cmd_word), {16'd0, mdl[5], mdl[4]});
        for (int n = 0; n < 6; n++) begin
            logic [31:0] e;
            for (int k = 0; k < 4; k++) e[k*8 +: 8] = mdl['h10 + n*4 + k];
            check(bar_raw[n*32 +: 32] == e, req, bar_raw[n*32 +: 32], e);
        end
        check(rom_raw == {mdl['h33], mdl['h32], mdl['h31], mdl['h30]}, req, rom_raw,
              {mdl['h33], mdl['h32], mdl['h31], mdl['h30]});
    endtask

    // Write; then check pulse, decoder outputs and that no read data appeared.
    task automatic do_write(input logic [7:0] ad, input logic [1:0] sz, input logic [31:0] d);
        bit p;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = ad; req_size = sz; req_wdata = d;
        model_write(ad, sz, d, p);
        @(negedge clk);
        req_valid = 0;
        check(map_changed == p, "R10 pulse", 32'(map_changed), 32'(p));
        check_outputs("R11 outputs");
        check(rd_valid == 1'b0, "R2 no rd_valid on write", 32'(rd_valid), 32'd0);
    endtask

    task automatic do_read(input logic [7:0] ad, input logic [1:0] sz, input string req);
        logic [31:0] e;
        e = model_read(ad, sz);
        @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = ad; req_size = sz;
        @(negedge clk);
        req_valid = 0;
        check(rd_valid == 1'b1, "R2 rd_valid", 32'(rd_valid), 32'd1);
        check(rd_data == e, req, rd_data, e);
        check(map_changed == 1'b0, "R10 no pulse on read", 32'(map_changed), 32'd0);
    endtask

    // R3: write immediately followed by a read of the same bytes.
    task automatic wr_then_rd(input logic [7:0] ad, input logic [1:0] sz, input logic [31:0] d);
        bit p;
        logic [31:0] e;
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = ad; req_size = sz; req_wdata = d;
        model_write(ad, sz, d, p);
        e = model_read(ad, sz);
        @(negedge clk);
        req_write = 0;
        check(map_changed == p, "R10 pulse back-to-back", 32'(map_changed), 32'(p));
        @(negedge clk);
        req_valid = 0;
        check(rd_valid == 1'b1 && rd_data == e, "R3 read after write", rd_data, e);
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        model_reset();
    endtask

    initial begin
        void'($urandom(32'd7321));
        rst_n = 0; req_valid = 0; req_write = 0; req_addr = 0; req_size = 0; req_wdata = 0;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R1: reset state at the ports and across the whole space.
        check(rd_valid == 1'b0, "R1 rd_valid after reset", 32'(rd_valid), 32'd0);
        check(map_changed == 1'b0, "R1 pulse after reset", 32'(map_changed), 32'd0);
        check_outputs("R1 outputs after reset");
        for (int a = 0; a < 256; a += 4) do_read(8'(a), 2'b10, "R1 reset image");
        do_read(8'h14, 2'b10, "R1 I/O BAR type bit");

        // R2: sizes and alignment.
        do_read(8'h01, 2'b00, "R2 single byte");
        do_read(8'h02, 2'b01, "R2 two bytes");
        do_read(8'h09, 2'b11, "R2 size code 11 reads four");

        // R4: read-only fields.
        do_write(8'h00, 2'b10, 32'h1234_5678);
        do_read(8'h00, 2'b10, "R4 ids read-only");
        do_write(8'h08, 2'b10, 32'hFFFF_FFFF);
        do_read(8'h08, 2'b10, "R4 rev/class read-only");
        do_write(8'h0E, 2'b00, 8'h81);
        do_read(8'h0E, 2'b00, "R4 header type read-only");
        do_write(8'h34, 2'b00, 8'h40);
        do_read(8'h34, 2'b00, "R4 cap pointer read-only");
        do_write(8'h06, 2'b01, 16'hFFFF);
        do_read(8'h06, 2'b01, "R4 status read-only");

        // R5: command bits and writable bytes.
        do_write(8'h04, 2'b01, 32'h0000_FFFF);
        do_read(8'h04, 2'b01, "R5 command mask");
        do_write(8'h04, 2'b00, 32'h04);          // I/O and memory off: pulse
        do_write(8'h04, 2'b00, 32'h00);          // master only: no pulse (R10)
        do_write(8'h0C, 2'b00, 32'hA5);
        do_read(8'h0C, 2'b00, "R5 cache line size");
        do_write(8'h3C, 2'b00, 32'h5A);
        do_read(8'h3C, 2'b00, "R5 interrupt line");
        do_write(8'h80, 2'b10, 32'hDEAD_BEEF);
        do_read(8'h80, 2'b10, "R5 device-specific");

        // R6: sizing writes.
        do_write(8'h10, 2'b10, 32'hFFFF_FFFF);
        do_read(8'h10, 2'b10, "R6 BAR0 size probe");
        do_write(8'h10, 2'b10, 32'hFFFF_FFFF);   // unchanged: no pulse (R10)
        do_write(8'h14, 2'b10, 32'hFFFF_FFFF);
        do_read(8'h14, 2'b10, "R6 BAR1 I/O size probe");
        do_write(8'h10, 2'b10, 32'h1234_5678);
        do_read(8'h10, 2'b10, "R6 BAR0 aligned address");

        // R7: ROM BAR.
        do_write(8'h30, 2'b10, 32'hFFFF_FFFF);
        do_read(8'h30, 2'b10, "R7 ROM size probe");
        do_write(8'h30, 2'b00, 32'h00);
        do_read(8'h30, 2'b10, "R7 ROM enable cleared");

        // R8: absent BAR.
        do_write(8'h18, 2'b10, 32'h0000_0000);
        do_read(8'h18, 2'b10, "R8 absent BAR");

        // R9: straddling the end of the space.
        do_write(8'hFE, 2'b10, 32'hAABB_CCDD);
        do_read(8'hFE, 2'b10, "R9 straddle read");
        do_read(8'hFF, 2'b01, "R9 last byte");
        do_read(8'h00, 2'b01, "R9 no wrap");

        // R3: back-to-back write and read.
        wr_then_rd(8'h50, 2'b10, 32'h0102_0304);
        wr_then_rd(8'h11, 2'b01, 32'h0000_ABCD);

        // R12: reset restores the software-owned fields.
        do_write(8'h04, 2'b00, 32'h07);
        pulse_reset();
        check_outputs("R12 outputs after reset");
        do_read(8'h0C, 2'b00, "R12 cache line cleared");
        do_read(8'h3C, 2'b00, "R12 interrupt line cleared");
        do_read(8'h10, 2'b10, "R12 BAR0 type only");
        do_read(8'h80, 2'b10, "R12 device byte cleared");

        // Random mix of reads and writes.
        for (int i = 0; i < 700; i++) begin
            logic [7:0]  ad;
            logic [1:0]  sz;
            logic [31:0] d;
            case ($urandom % 4)
                0: ad = 8'($urandom % 256);
                1: ad = 8'h10 + 8'($urandom % 40);
                2: ad = 8'hFC + 8'($urandom % 4);
                default: ad = ($urandom % 2) ? 8'h04 : 8'h0C;
            endcase
            sz = 2'($urandom % 4);
            d  = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            case ($urandom % 3)
                0: do_read(ad, sz, "R2 random read");
                1: do_write(ad, sz, d);
                default: wr_then_rd(ad, sz, d);
            endcase
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog all requirements actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule